// File: doc/BRIEF.md
# Isochronous IN Endpoint Ping-Pong Transmitter

This block is the device-side transmit engine for a single isochronous IN endpoint. Firmware pushes payload bytes into one half of a two-bank buffer and marks that half as ready. The other half belongs to the frame in progress and is the one returned to the host. Each start-of-frame token swaps the two halves, so a packet prepared during frame n is answered on the IN token of frame n+1. Packets carry no handshake and are never retried, and the data PID is always DATA0.

The token decoder upstream reports each token as a kind, an address, an endpoint number and an error flag. When an IN token matches the configured address and endpoint, carries no error, and the endpoint is set up for isochronous IN, the block streams PID, payload and CRC16 one byte per accepted beat toward the serial engine. The serial engine paces the stream with a ready signal. When the current-frame half holds no committed data, a zero-length packet goes out.

Top module: `iso_in_ep`

## Requirements
- R1: After reset `tx_valid`, `tx_last` and `underrun` are 0. Both halves hold no committed data, and bank A takes firmware writes, so an IN token before the first SOF yields a zero-length packet.
- R2: An IN token (`tok_kind` = 2'b01) is accepted only while idle. If it matches, `tx_valid` rises on the next cycle and the first byte is the DATA0 PID 0xC3.
- R3: An IN token is dropped with no output if `tok_addr` differs from `cfg_addr`, `tok_ep` differs from `cfg_ep`, or `tok_err` is 1. Token kinds 2'b00 and 2'b11 are also dropped.
- R4: While `cfg_iso_in` is 0 no IN token starts a packet.
- R5: Bytes written and committed during one frame are not sent in that frame. They are sent in write order on the IN token that follows the next SOF (`tok_kind` = 2'b10).
- R6: If the current-frame half has no committed data, the packet is exactly 0xC3, 0x00, 0x00.
- R7: The CRC16 follows the payload. It uses polynomial x^16+x^15+x^2+1, is preset to 0xFFFF, and processes each byte least significant bit first. Its complement is sent low byte first. `tx_last` marks the high CRC byte, and `tx_valid` falls after that byte is accepted.
- R8: Each SOF swaps the halves and discards the leaving half's data. A committed packet not read by an IN in its frame is lost after the following SOF, and later IN tokens send zero-length packets.
- R9: Writes to the next-frame half are ignored once it is committed, and also beyond `DEPTH` bytes, until the next SOF frees it.
- R10: One cycle after an SOF, `underrun` pulses high for one cycle if the half leaving the current-frame role held committed data that was never fully sent.
- R11: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` and `tx_data` hold their values.
- R12: IN and SOF tokens that arrive while a packet is being streamed are ignored. No second packet follows, and the halves are not swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | ADDR_W | Device address to match |
| cfg_ep | input | EP_W | Endpoint number to match |
| cfg_iso_in | input | 1 | Endpoint is configured as isochronous IN |
| wr_valid | input | 1 | Firmware byte write into the next-frame half |
| wr_byte | input | 8 | Byte written |
| wr_commit | input | 1 | Marks the next-frame half ready to send |
| tok_valid | input | 1 | Token present for one cycle |
| tok_kind | input | 2 | 01 IN, 10 SOF, others ignored |
| tok_addr | input | ADDR_W | Token address |
| tok_ep | input | EP_W | Token endpoint number |
| tok_err | input | 1 | Token failed its own check |
| tx_ready | input | 1 | Serial engine accepts the current byte |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Current byte is the last of the packet |
| underrun | output | 1 | One-cycle pulse: a committed packet left unsent |

## Verification
The case hardest to reach from the ports is an SOF that retires a committed half the host never read. It needs a commit in one frame, a swap, a frame with no matching IN, and then a second swap, while the data written alongside goes into the other half. The stimulus reaches it with a directed run of that exact sequence, and also with random frames in which the number of IN tokens, including zero, is drawn per frame. The bench models both halves and predicts the pulse at every SOF. Tokens injected in the middle of a packet check that a busy engine neither restarts nor swaps.

// File: rtl/iso_pkg.sv
`timescale 1ns/1ps
package iso_pkg;

  typedef enum logic [1:0] {
    TK_NONE = 2'b00,
    TK_IN   = 2'b01,
    TK_SOF  = 2'b10,
    TK_RSVD = 2'b11
  } tok_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PID,
    ST_DATA,
    ST_CRC_LO,
    ST_CRC_HI
  } tx_state_e;

  localparam logic [7:0]  PID_DATA0   = 8'hC3;
  localparam logic [15:0] CRC16_SEED  = 16'hFFFF;
  localparam logic [15:0] CRC16_RPOLY = 16'hA001;  // reflected x^16+x^15+x^2+1

  // One byte of the bus CRC16, least significant bit first.
  function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                             input logic [7:0]  din);
    logic [15:0] c;
    c = crc_in ^ {8'h00, din};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC16_RPOLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/iso_crc16.sv
`timescale 1ns/1ps
module iso_crc16
  import iso_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc_out
);

  logic [15:0] crc_q;
  logic [15:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clear) begin
      crc_d = CRC16_SEED;
    end else if (en) begin
      crc_d = crc16_step(crc_q, din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC16_SEED;
    end else begin
      crc_q <= crc_d;
    end
  end

  // Transmitted value is the complemented remainder.
  assign crc_out = ~crc_q;

endmodule

// File: rtl/iso_pp_buffer.sv
`timescale 1ns/1ps
module iso_pp_buffer #(
  parameter int DEPTH = 64,
  parameter int PTR_W = 6,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic             wr_commit,
  input  logic             swap,
  input  logic             mark_sent,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [7:0]       rd_byte,
  output logic [LEN_W-1:0] x_len,
  output logic             x_ready,
  output logic             underrun
);

  logic                  x_sel_q;
  logic                  x_sel_d;
  logic                  under_q;
  logic                  under_d;
  logic [1:0][7:0]       bank_rd;
  logic [1:0][LEN_W-1:0] bank_len;
  logic [1:0]            bank_set;
  logic [1:0]            bank_sent;

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [7:0]       store [DEPTH];
      logic [LEN_W-1:0] len_q;
      logic [LEN_W-1:0] len_d;
      logic             set_q;
      logic             set_d;
      logic             sent_q;
      logic             sent_d;
      logic             is_x;
      logic             wr_take;

      always_comb begin
        is_x    = (x_sel_q == 1'(b));
        wr_take = !is_x && wr_en && !set_q && (len_q < LEN_W'(DEPTH));
        len_d   = len_q;
        set_d   = set_q;
        sent_d  = sent_q;
        if (wr_take) begin
          len_d = len_q + 1'b1;
        end
        if (!is_x && wr_commit) begin
          set_d = 1'b1;
        end
        if (is_x && mark_sent) begin
          sent_d = 1'b1;
        end
        if (swap && is_x) begin
          len_d  = '0;
          set_d  = 1'b0;
          sent_d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          len_q  <= '0;
          set_q  <= 1'b0;
          sent_q <= 1'b0;
        end else begin
          len_q  <= len_d;
          set_q  <= set_d;
          sent_q <= sent_d;
        end
      end

      // Payload storage carries no reset.
      always_ff @(posedge clk) begin
        if (wr_take) begin
          store[len_q[PTR_W-1:0]] <= wr_byte;
        end
      end

      assign bank_rd[b]   = store[rd_ptr];
      assign bank_len[b]  = len_q;
      assign bank_set[b]  = set_q;
      assign bank_sent[b] = sent_q;
    end
  endgenerate

  always_comb begin
    x_sel_d = swap ? ~x_sel_q : x_sel_q;
    under_d = swap && bank_set[x_sel_q] && !bank_sent[x_sel_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_sel_q <= 1'b1;   // bank A starts in the next-frame role
      under_q <= 1'b0;
    end else begin
      x_sel_q <= x_sel_d;
      under_q <= under_d;
    end
  end

  assign rd_byte  = bank_rd[x_sel_q];
  assign x_len    = bank_len[x_sel_q];
  assign x_ready  = bank_set[x_sel_q];
  assign underrun = under_q;

endmodule

// File: rtl/iso_tx_fsm.sv
`timescale 1ns/1ps
module iso_tx_fsm
  import iso_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int PTR_W  = 6,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              tok_err,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [EP_W-1:0]   cfg_ep,
  input  logic              cfg_iso_in,
  input  logic              x_ready,
  input  logic [LEN_W-1:0]  x_len,
  input  logic [7:0]        rd_byte,
  input  logic [15:0]       crc_val,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              crc_clear,
  output logic              crc_en,
  output logic              mark_sent,
  output logic              swap
);

  tx_state_e        st_q;
  tx_state_e        st_d;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;
  logic             full_q;
  logic             full_d;
  logic             idle;
  logic             tok_in;
  logic             tok_sof;
  logic             hit;
  logic             beat;

  always_comb begin
    idle    = (st_q == ST_IDLE);
    tok_in  = tok_valid && (tok_kind_e'(tok_kind) == TK_IN);
    tok_sof = tok_valid && (tok_kind_e'(tok_kind) == TK_SOF);
    hit     = idle && tok_in && !tok_err && cfg_iso_in &&
              (tok_addr == cfg_addr) && (tok_ep == cfg_ep);

    tx_valid = !idle;
    tx_last  = (st_q == ST_CRC_HI);
    case (st_q)
      ST_PID:    tx_data = PID_DATA0;
      ST_DATA:   tx_data = rd_byte;
      ST_CRC_LO: tx_data = crc_val[7:0];
      ST_CRC_HI: tx_data = crc_val[15:8];
      default:   tx_data = 8'h00;
    endcase
    beat = tx_valid && tx_ready;
  end

  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    cnt_d     = cnt_q;
    full_d    = full_q;
    crc_clear = 1'b0;
    crc_en    = 1'b0;
    mark_sent = 1'b0;
    swap      = idle && tok_sof;
    case (st_q)
      ST_IDLE: begin
        if (hit) begin
          st_d      = ST_PID;
          ptr_d     = '0;
          cnt_d     = x_ready ? x_len : '0;
          full_d    = x_ready;
          crc_clear = 1'b1;
        end
      end
      ST_PID: begin
        if (beat) begin
          st_d = (cnt_q != '0) ? ST_DATA : ST_CRC_LO;
        end
      end
      ST_DATA: begin
        if (beat) begin
          crc_en = 1'b1;
          ptr_d  = ptr_q + 1'b1;
          if ((LEN_W'(ptr_q) + 1'b1) == cnt_q) begin
            st_d = ST_CRC_LO;
          end
        end
      end
      ST_CRC_LO: begin
        if (beat) begin
          st_d = ST_CRC_HI;
        end
      end
      ST_CRC_HI: begin
        if (beat) begin
          st_d      = ST_IDLE;
          mark_sent = full_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  assign rd_ptr = ptr_q;

endmodule

// File: rtl/iso_in_ep.sv
`timescale 1ns/1ps
module iso_in_ep #(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [EP_W-1:0]   cfg_ep,
  input  logic              cfg_iso_in,
  input  logic              wr_valid,
  input  logic [7:0]        wr_byte,
  input  logic              wr_commit,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              tok_err,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              underrun
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic             rst_meta_n;
  logic             rst_sync_n;
  logic [PTR_W-1:0] rd_ptr;
  logic [7:0]       rd_byte;
  logic [LEN_W-1:0] x_len;
  logic             x_ready;
  logic [15:0]      crc_val;
  logic             crc_clear;
  logic             crc_en;
  logic             mark_sent;
  logic             swap;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  iso_pp_buffer #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W),
    .LEN_W (LEN_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_valid),
    .wr_byte   (wr_byte),
    .wr_commit (wr_commit),
    .swap      (swap),
    .mark_sent (mark_sent),
    .rd_ptr    (rd_ptr),
    .rd_byte   (rd_byte),
    .x_len     (x_len),
    .x_ready   (x_ready),
    .underrun  (underrun)
  );

  iso_crc16 u_crc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear   (crc_clear),
    .en      (crc_en),
    .din     (rd_byte),
    .crc_out (crc_val)
  );

  iso_tx_fsm #(
    .ADDR_W (ADDR_W),
    .EP_W   (EP_W),
    .PTR_W  (PTR_W),
    .LEN_W  (LEN_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tok_valid  (tok_valid),
    .tok_kind   (tok_kind),
    .tok_addr   (tok_addr),
    .tok_ep     (tok_ep),
    .tok_err    (tok_err),
    .cfg_addr   (cfg_addr),
    .cfg_ep     (cfg_ep),
    .cfg_iso_in (cfg_iso_in),
    .x_ready    (x_ready),
    .x_len      (x_len),
    .rd_byte    (rd_byte),
    .crc_val    (crc_val),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .rd_ptr     (rd_ptr),
    .crc_clear  (crc_clear),
    .crc_en     (crc_en),
    .mark_sent  (mark_sent),
    .swap       (swap)
  );

endmodule

// File: rtl/iso_in_ep_chk.sv
`timescale 1ns/1ps
module iso_in_ep_chk #(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [EP_W-1:0]   cfg_ep,
  input logic              cfg_iso_in,
  input logic              tok_valid,
  input logic [1:0]        tok_kind,
  input logic [ADDR_W-1:0] tok_addr,
  input logic [EP_W-1:0]   tok_ep,
  input logic              tx_ready,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic              underrun
);

  p_pid_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_data == 8'hC3);

  p_addr_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && tok_valid && tok_kind == 2'b01 &&
     (tok_addr != cfg_addr || tok_ep != cfg_ep)) |=> !tx_valid);

  p_mode_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && tok_valid && !cfg_iso_in) |=> !tx_valid);

  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  p_end_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

  p_underrun_after_sof_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(tok_valid && tok_kind == 2'b10 && !tx_valid));

  p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

bind iso_in_ep iso_in_ep_chk #(.ADDR_W(ADDR_W), .EP_W(EP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_addr   (cfg_addr),
  .cfg_ep     (cfg_ep),
  .cfg_iso_in (cfg_iso_in),
  .tok_valid  (tok_valid),
  .tok_kind   (tok_kind),
  .tok_addr   (tok_addr),
  .tok_ep     (tok_ep),
  .tx_ready   (tx_ready),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .tx_last    (tx_last),
  .underrun   (underrun)
);

// File: tb/sim_iso_in_ep.sv
`timescale 1ns/1ps
module sim_iso_in_ep;

  localparam int DEPTH = 64;
  localparam logic [6:0] MY_ADDR = 7'h2A;
  localparam logic [3:0] MY_EP   = 4'h5;

  logic       clk;
  logic       rst_n;
  logic [6:0] cfg_addr;
  logic [3:0] cfg_ep;
  logic       cfg_iso_in;
  logic       wr_valid;
  logic [7:0] wr_byte;
  logic       wr_commit;
  logic       tok_valid;
  logic [1:0] tok_kind;
  logic [6:0] tok_addr;
  logic [3:0] tok_ep;
  logic       tok_err;
  logic       tx_ready;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_last;
  logic       underrun;

  iso_in_ep u0 (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_ep(cfg_ep),
    .cfg_iso_in(cfg_iso_in), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .wr_commit(wr_commit), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .tok_addr(tok_addr), .tok_ep(tok_ep), .tok_err(tok_err),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench model of both halves.
  logic [7:0] mdl [2][DEPTH];
  int  mlen [2];
  bit  mset [2];
  bit  msent[2];
  int  mx;

  logic [7:0] got [DEPTH+4];
  int  got_n;
  logic [7:0] exp_b [DEPTH+4];
  int  exp_n;
  bit  hold_bad;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_crc16(input int bank, input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, mdl[bank][i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic void build_expected();
    int n;
    logic [15:0] c;
    n = mset[mx] ? mlen[mx] : 0;
    exp_b[0] = 8'hC3;
    for (int i = 0; i < n; i++) exp_b[1+i] = mdl[mx][i];
    c = ref_crc16(mx, n);
    exp_b[n+1] = c[7:0];
    exp_b[n+2] = c[15:8];
    exp_n = n + 3;
  endfunction

  task automatic send_tok(input logic [1:0] kind, input logic [6:0] a,
                          input logic [3:0] e, input bit err);
    @(negedge clk);
    tx_ready  = 1'b0;
    tok_valid = 1'b1;
    tok_kind  = kind;
    tok_addr  = a;
    tok_ep    = e;
    tok_err   = err;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  // Collects one packet; optionally injects a token one cycle in.
  task automatic collect(input logic [1:0] inject);
    bit fin;
    bit stall;
    logic [7:0] held;
    int guard;
    fin = 0; stall = 0; held = 8'h00; guard = 0; got_n = 0; hold_bad = 0;
    while (!fin && guard < 4 * DEPTH + 64) begin
      @(negedge clk);
      if (stall && tx_valid && tx_data != held) hold_bad = 1;
      if (stall && !tx_valid) hold_bad = 1;
      tx_ready  = ($urandom % 4) != 0;
      tok_valid = (inject != 2'b00) && (guard == 1);
      tok_kind  = inject;
      tok_addr  = MY_ADDR;
      tok_ep    = MY_EP;
      tok_err   = 1'b0;
      stall = tx_valid && !tx_ready;
      held  = tx_data;
      if (tx_valid && tx_ready) begin
        if (got_n < DEPTH + 4) got[got_n] = tx_data;
        got_n++;
        if (tx_last) fin = 1;
      end
      guard++;
    end
    @(negedge clk);
    tok_valid = 1'b0;
    tx_ready  = 1'b0;
  endtask

  task automatic check_packet(input string tag);
    int bad;
    bad = -1;
    if (got_n == exp_n) begin
      for (int i = 0; i < exp_n; i++) if (bad < 0 && got[i] != exp_b[i]) bad = i;
      if (bad < 0) chk(1, tag, "packet", 0, 0);
      else chk(0, tag, $sformatf("byte %0d", bad), got[bad], exp_b[bad]);
    end else begin
      chk(0, tag, "packet length", got_n, exp_n);
    end
    chk(!hold_bad, "R11", "data held while stalled", hold_bad, 0);
  endtask

  task automatic do_in(input string tag, input logic [1:0] inject);
    build_expected();
    send_tok(2'b01, MY_ADDR, MY_EP, 1'b0);
    collect(inject);
    check_packet(tag);
    if (mset[mx]) msent[mx] = 1;
  endtask

  task automatic no_packet(input string tag);
    bit seen;
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (tx_valid) seen = 1;
    end
    chk(!seen, tag, "no packet expected, tx_valid", seen, 0);
  endtask

  task automatic do_sof(input string tag);
    bit eu;
    eu = mset[mx] && !msent[mx];
    send_tok(2'b10, 7'h00, 4'h0, 1'b0);
    chk(underrun == eu, tag, "underrun after SOF", underrun, eu);
    mset[mx] = 0; mlen[mx] = 0; msent[mx] = 0;
    mx = 1 - mx;
  endtask

  task automatic write_bytes(input int n);
    int y;
    y = 1 - mx;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_byte  = 8'($urandom);
      if (!mset[y] && mlen[y] < DEPTH) begin
        mdl[y][mlen[y]] = wr_byte;
        mlen[y]++;
      end
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    wr_commit = 1'b1;
    @(negedge clk);
    wr_commit = 1'b0;
    mset[1-mx] = 1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_addr = MY_ADDR; cfg_ep = MY_EP; cfg_iso_in = 1'b1;
    wr_valid = 1'b0; wr_byte = 8'h00; wr_commit = 1'b0;
    tok_valid = 1'b0; tok_kind = 2'b00; tok_addr = 7'h00; tok_ep = 4'h0;
    tok_err = 1'b0; tx_ready = 1'b0;
    mx = 1;
    for (int b = 0; b < 2; b++) begin mlen[b] = 0; mset[b] = 0; msent[b] = 0; end
    repeat (3) @(negedge clk);
    chk(!tx_valid && !tx_last && !underrun, "R1", "outputs in reset",
        {tx_valid, tx_last, underrun}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!tx_valid && !underrun, "R1", "outputs after reset", {tx_valid, underrun}, 0);

    // R6 with literal bytes, R1 start state
    send_tok(2'b01, MY_ADDR, MY_EP, 1'b0);
    collect(2'b00);
    chk(got_n == 3 && got[0] == 8'hC3 && got[1] == 8'h00 && got[2] == 8'h00,
        "R6", "empty packet C3 00 00", {got[0], got[1], got[2]}, 24'hC30000);

    // R5: committed data is not sent in the same frame
    write_bytes(5);
    commit();
    do_in("R5", 2'b00);
    do_sof("R10");
    do_in("R7", 2'b00);

    // R3 / R4 rejections
    send_tok(2'b01, MY_ADDR ^ 7'h01, MY_EP, 1'b0); no_packet("R3");
    send_tok(2'b01, MY_ADDR, MY_EP ^ 4'h8, 1'b0);  no_packet("R3");
    send_tok(2'b01, MY_ADDR, MY_EP, 1'b1);         no_packet("R3");
    send_tok(2'b11, MY_ADDR, MY_EP, 1'b0);         no_packet("R3");
    send_tok(2'b00, MY_ADDR, MY_EP, 1'b0);         no_packet("R3");
    cfg_iso_in = 1'b0;
    send_tok(2'b01, MY_ADDR, MY_EP, 1'b0);         no_packet("R4");
    cfg_iso_in = 1'b1;

    // R9: overflow beyond DEPTH and writes after commit
    write_bytes(DEPTH + 6);
    commit();
    write_bytes(4);
    do_sof("R10");
    do_in("R9", 2'b00);

    // R8 / R10: committed packet never read
    write_bytes(3);
    commit();
    do_sof("R10");
    do_sof("R10");
    do_in("R8", 2'b00);

    // R12: tokens during a packet
    write_bytes(4);
    commit();
    do_sof("R10");
    do_in("R12", 2'b01);
    no_packet("R12");
    do_in("R12", 2'b10);
    do_in("R12", 2'b00);

    // Random frames
    for (int f = 0; f < 40; f++) begin
      int nin;
      if (($urandom % 5) != 0) write_bytes($urandom % (DEPTH + 6));
      if (($urandom % 4) != 0) commit();
      nin = $urandom % 3;
      for (int k = 0; k < nin; k++) begin
        if (($urandom % 3) == 0) begin
          send_tok(2'b01, MY_ADDR, 4'(MY_EP + 4'(1 + $urandom % 15)), 1'b0);
          no_packet("R3");
        end
        do_in("R5", 2'b00);
      end
      do_sof("R10");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule